// File: doc/BRIEF.md
# Processor Cold/Warm Reset Sequencer

This block lives in a board controller and owns the two active-low reset inputs of a processor. One of them is a full (cold) initialization and the other is a logical (warm) initialization. The block watches a core-supply-good flag and an I/O-supply-good flag. The two supplies may come up in either order. The second one must come up within a bounded window after the first, and a late arrival latches a power fault. Once both supplies are good, the cold reset is held for a long settling count. The cold line is then released, and the warm line follows a fixed number of clocks later. A ready flag rises one clock after that.

While the processor runs, a warm-reset request pulses only the warm line for a fixed count and leaves the cold line high. If either supply drops at any time, both reset lines go low at once through combinational gating, and the whole sequence starts again. The block also drives the processor's configuration straps: bus width, byte order, clock divide code and return-order mode. The straps come from parameters and are valid before the cold reset ends. They never move while the processor runs.

All cycle counts are parameters, so a simulation can use small values. Deassertion of either reset always happens on a clock edge.

Top module: `cpu_rst_seq`

## Requirements
- R1: While `rst_n` is low, `cold_rst_n`, `warm_rst_n`, `ready` and `pwr_fault` are all 0.
- R2: When exactly one supply is good for SKEW_MS*CLKS_PER_MS consecutive clock edges, `pwr_fault` goes to 1 on the edge that completes the count. If the second supply arrives after one edge fewer, no fault is raised.
- R3: After both supplies are first sampled good, `cold_rst_n` stays low for HOLD_CYC+1 clock edges, which is never fewer than HOLD_CYC. It rises on a clock edge.
- R4: `warm_rst_n` rises GAP_CYC clock edges after `cold_rst_n` rises. `warm_rst_n` is never high while `cold_rst_n` is low.
- R5: `ready` rises one clock edge after `warm_rst_n` rises. It is high only while both resets are released.
- R6: A high `warm_req` sampled while `ready` is high drives `warm_rst_n` low for WARM_CYC clock edges and drops `ready`. `cold_rst_n` stays high throughout. `ready` returns one edge after `warm_rst_n` rises.
- R7: A `warm_req` that arrives during cold-reset sequencing has no effect: the release timing of R3 and R4 is unchanged.
- R8: When either supply flag goes low, `cold_rst_n`, `warm_rst_n` and `ready` go low in the same cycle, without waiting for a clock edge. When both supplies are good again, the full sequence of R3 to R5 repeats.
- R9: Once `pwr_fault` is set, both resets stay low even if both supplies become good. The fault clears only when both supply flags are low.
- R10: The strap outputs equal their parameters: `strap_bus64`, `strap_big_endian`, `strap_ooo_ret` and the 3-bit `strap_div`. `div_ratio_x2` equals `strap_div`+4, so code 000 means ratio 2 and code 111 means ratio 5.5, in steps of 0.5. The straps are stable whenever `cold_rst_n` has been high for two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Board-controller reset, active low, asynchronous |
| core_ok | input | 1 | Core supply good |
| io_ok | input | 1 | I/O supply good |
| warm_req | input | 1 | Warm reset request, level sampled on the clock |
| cold_rst_n | output | 1 | Cold reset to the processor, active low |
| warm_rst_n | output | 1 | Warm reset to the processor, active low |
| ready | output | 1 | Processor released from both resets |
| pwr_fault | output | 1 | Supply arrival window exceeded |
| strap_bus64 | output | 1 | Bus width strap, 1 selects 64 bits |
| strap_big_endian | output | 1 | Byte order strap, 1 selects big endian |
| strap_div | output | 3 | Clock divide strap code |
| div_ratio_x2 | output | 4 | Divide ratio in half steps (code+4) |
| strap_ooo_ret | output | 1 | Out-of-order return strap |

## Verification
The assertions assume that both supply flags and `warm_req` are clean levels that change only between clock edges. They also assume that `rst_n` is asserted before the first edge that counts. The bench meets these assumptions by driving every input on the falling edge and sampling outputs there. The only exception is the supply-drop check, which looks a moment after the falling edge to see the combinational gating. Short cycle-count parameters keep the skew window, the hold count and both pulse counts small enough for each boundary to be hit exactly. A hold count of 64 is used in place of the default 65536.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_HOLD = 3'd1,
        ST_GAP  = 3'd2,
        ST_RUN  = 3'd3,
        ST_WARM = 3'd4
    } seq_st_e;

    typedef struct packed {
        logic       bus64;
        logic       big_endian;
        logic [2:0] div_code;
        logic [3:0] ratio_x2;
        logic       ooo_ret;
    } strap_s;

endpackage

// File: rtl/rst_seq_win.sv
module rst_seq_win #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_ok,
    input  logic io_ok,
    output logic fault_o
);
    localparam int WW = $clog2(LIMIT + 1);
    localparam logic [WW-1:0] LAST = WW'(LIMIT - 1);

    typedef struct packed {
        logic [WW-1:0] cnt;
        logic          fault;
    } win_s;

    win_s q, d;
    logic only_one, none_up;

    always_comb begin
        only_one = core_ok ^ io_ok;
        none_up  = !core_ok && !io_ok;
        d = q;
        if (none_up) begin
            d.cnt   = '0;
            d.fault = 1'b0;
        end else if (only_one) begin
            if (!q.fault) begin
                if (q.cnt == LAST) d.fault = 1'b1;
                else               d.cnt   = q.cnt + WW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fault_o = q.fault;

    // R2: a fault appears only after a cycle with exactly one supply up
    a_r2_fault_on_skew: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.fault) |-> $past(core_ok ^ io_ok));

    // R9: fault persists while any supply is up
    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fault && (core_ok || io_ok)) |=> q.fault);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int HOLD_CYC = 65536,
    parameter int GAP_CYC  = 16,
    parameter int WARM_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic fault,
    input  logic warm_req,
    output logic cold_q_o,
    output logic warm_q_o,
    output logic rdy_q_o
);
    localparam int MAX_HG = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int MAXC   = (MAX_HG > WARM_CYC) ? MAX_HG : WARM_CYC;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);
    localparam logic [CW-1:0] WARM_LAST = CW'(WARM_CYC - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic          cold;
        logic          warm;
        logic          rdy;
    } fsm_s;

    fsm_s q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_OFF: begin
                d.cold = 1'b0;
                d.warm = 1'b0;
                d.rdy  = 1'b0;
                d.cnt  = '0;
                if (supply_ok && !fault) d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (q.cnt == HOLD_LAST) begin
                    d.st   = ST_GAP;
                    d.cnt  = '0;
                    d.cold = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_GAP: begin
                if (q.cnt == GAP_LAST) begin
                    d.st   = ST_RUN;
                    d.cnt  = '0;
                    d.warm = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_RUN: begin
                d.rdy = 1'b1;
                if (warm_req) begin
                    d.st   = ST_WARM;
                    d.cnt  = '0;
                    d.warm = 1'b0;
                    d.rdy  = 1'b0;
                end
            end
            ST_WARM: begin
                if (q.cnt == WARM_LAST) begin
                    d.st   = ST_RUN;
                    d.cnt  = '0;
                    d.warm = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.st = ST_OFF;
        endcase
        if (!supply_ok) begin
            d.st   = ST_OFF;
            d.cnt  = '0;
            d.cold = 1'b0;
            d.warm = 1'b0;
            d.rdy  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_OFF, cnt: '0, cold: 1'b0, warm: 1'b0, rdy: 1'b0};
        else        q <= d;
    end

    assign cold_q_o = q.cold;
    assign warm_q_o = q.warm;
    assign rdy_q_o  = q.rdy;

    // R7: the warm pulse state is entered only from the running state
    a_r7_warm_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WARM) |-> ($past(q.st) == ST_RUN || $past(q.st) == ST_WARM));

    // R5: ready rises only after the warm line was already released
    a_r5_ready_after_warm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rdy) |-> ($past(q.warm) && q.warm && q.cold));

endmodule

// File: rtl/rst_seq_strap.sv
module rst_seq_strap
    import rst_seq_pkg::*;
#(
    parameter bit         BUS64      = 1'b1,
    parameter bit         BIG_ENDIAN = 1'b0,
    parameter logic [2:0] DIV_CODE   = 3'd2,
    parameter bit         OOO_RET    = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hold_i,
    output strap_s strap_o
);
    localparam strap_s CFG = '{
        bus64:      BUS64,
        big_endian: BIG_ENDIAN,
        div_code:   DIV_CODE,
        ratio_x2:   4'(DIV_CODE) + 4'd4,
        ooo_ret:    OOO_RET
    };

    strap_s q, d;

    always_comb begin
        d = q;
        if (hold_i) d = CFG;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CFG;
        else        q <= d;
    end

    assign strap_o = q;

    // R10: straps never move while the processor is out of cold reset
    a_r10_strap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !$past(hold_i)) |-> $stable(q));

endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
    import rst_seq_pkg::*;
#(
    parameter int         CLKS_PER_MS = 133000,
    parameter int         SKEW_MS     = 100,
    parameter int         HOLD_CYC    = 65536,
    parameter int         GAP_CYC     = 16,
    parameter int         WARM_CYC    = 16,
    parameter bit         STRAP_BUS64 = 1'b1,
    parameter bit         STRAP_BIG   = 1'b0,
    parameter logic [2:0] STRAP_DIV   = 3'd2,
    parameter bit         STRAP_OOO   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       core_ok,
    input  logic       io_ok,
    input  logic       warm_req,
    output logic       cold_rst_n,
    output logic       warm_rst_n,
    output logic       ready,
    output logic       pwr_fault,
    output logic       strap_bus64,
    output logic       strap_big_endian,
    output logic [2:0] strap_div,
    output logic [3:0] div_ratio_x2,
    output logic       strap_ooo_ret
);
    localparam int SKEW_LIMIT = CLKS_PER_MS * SKEW_MS;
    localparam int MIN_PULSE  = (GAP_CYC < WARM_CYC) ? GAP_CYC : WARM_CYC;
    localparam int HW         = $clog2(HOLD_CYC + 2);
    localparam int PW         = $clog2(MIN_PULSE + 2);

    logic   supply_ok, fault, cold_q, warm_q, rdy_q;
    strap_s straps;

    assign supply_ok = core_ok & io_ok;

    rst_seq_win #(.LIMIT(SKEW_LIMIT)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .core_ok (core_ok),
        .io_ok   (io_ok),
        .fault_o (fault)
    );

    rst_seq_fsm #(
        .HOLD_CYC (HOLD_CYC),
        .GAP_CYC  (GAP_CYC),
        .WARM_CYC (WARM_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .fault     (fault),
        .warm_req  (warm_req),
        .cold_q_o  (cold_q),
        .warm_q_o  (warm_q),
        .rdy_q_o   (rdy_q)
    );

    rst_seq_strap #(
        .BUS64      (STRAP_BUS64),
        .BIG_ENDIAN (STRAP_BIG),
        .DIV_CODE   (STRAP_DIV),
        .OOO_RET    (STRAP_OOO)
    ) u_strap (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (!cold_rst_n),
        .strap_o (straps)
    );

    // assertion is immediate on supply loss, release waits for the edge
    assign cold_rst_n       = cold_q & supply_ok;
    assign warm_rst_n       = warm_q & supply_ok;
    assign ready            = rdy_q & supply_ok;
    assign pwr_fault        = fault;
    assign strap_bus64      = straps.bus64;
    assign strap_big_endian = straps.big_endian;
    assign strap_div        = straps.div_code;
    assign div_ratio_x2     = straps.ratio_x2;
    assign strap_ooo_ret    = straps.ooo_ret;

    // checker counters: low time of each reset line, counted independently
    logic [HW-1:0] chk_cold_q;
    logic [PW-1:0] chk_warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_cold_q <= '0;
            chk_warm_q <= '0;
        end else begin
            if (supply_ok && !cold_rst_n)
                chk_cold_q <= (chk_cold_q == HW'(HOLD_CYC)) ? chk_cold_q : chk_cold_q + HW'(1);
            else
                chk_cold_q <= '0;
            if (cold_rst_n && !warm_rst_n)
                chk_warm_q <= (chk_warm_q == PW'(MIN_PULSE)) ? chk_warm_q : chk_warm_q + PW'(1);
            else
                chk_warm_q <= '0;
        end
    end

    // R3: cold reset held at least HOLD_CYC cycles with both supplies good
    a_r3_cold_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cold_rst_n) |-> (chk_cold_q >= HW'(HOLD_CYC)));

    // R4: warm line never released ahead of the cold line
    a_r4_order: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst_n |-> cold_rst_n);

    // R6: warm low time after cold release covers the minimum pulse
    a_r6_warm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(warm_rst_n) && $past(cold_rst_n)) |-> (chk_warm_q >= PW'(MIN_PULSE)));

    // R8: after a supply loss, ready is still low on the next edge
    a_r8_loss_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !ready);

endmodule

// File: tb/sim_cpu_rst_seq.sv
module sim_cpu_rst_seq;
    localparam int CPM   = 4;
    localparam int SKMS  = 5;
    localparam int LIMIT = CPM * SKMS;
    localparam int HOLD  = 64;
    localparam int GAP   = 16;
    localparam int WARM  = 16;

    logic clk = 1'b0;
    logic rst_n, core_ok, io_ok, warm_req;
    logic cold_rst_n, warm_rst_n, ready, pwr_fault;
    logic strap_bus64, strap_big_endian, strap_ooo_ret;
    logic [2:0] strap_div;
    logic [3:0] div_ratio_x2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpu_rst_seq #(
        .CLKS_PER_MS (CPM),
        .SKEW_MS     (SKMS),
        .HOLD_CYC    (HOLD),
        .GAP_CYC     (GAP),
        .WARM_CYC    (WARM),
        .STRAP_BUS64 (1'b1),
        .STRAP_BIG   (1'b1),
        .STRAP_DIV   (3'd5),
        .STRAP_OOO   (1'b0)
    ) u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .core_ok          (core_ok),
        .io_ok            (io_ok),
        .warm_req         (warm_req),
        .cold_rst_n       (cold_rst_n),
        .warm_rst_n       (warm_rst_n),
        .ready            (ready),
        .pwr_fault        (pwr_fault),
        .strap_bus64      (strap_bus64),
        .strap_big_endian (strap_big_endian),
        .strap_div        (strap_div),
        .div_ratio_x2     (div_ratio_x2),
        .strap_ooo_ret    (strap_ooo_ret)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // measures edges to cold release, then warm release, then ready
    task automatic measure_boot(input string tag, input int pulse_at);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (pulse_at > 0) warm_req = (n >= pulse_at && n < pulse_at + 3);
        end while (!cold_rst_n && n < 1000);
        warm_req = 1'b0;
        check({tag, " R3 cold hold"}, n, HOLD + 1);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            check({tag, " R4 order"}, int'(warm_rst_n && !cold_rst_n), 0);
        end while (!warm_rst_n && n < 1000);
        check({tag, " R4 gap"}, n, GAP);
        check({tag, " R5 ready lags"}, int'(ready), 0);
        @(negedge clk);
        check({tag, " R5 ready"}, int'(ready), 1);
    endtask

    task automatic drop_all();
        core_ok = 1'b0;
        io_ok   = 1'b0;
        wait_neg(2);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; core_ok = 1'b0; io_ok = 1'b0; warm_req = 1'b0;
        wait_neg(3);
        check("R1 cold", int'(cold_rst_n), 0);
        check("R1 warm", int'(warm_rst_n), 0);
        check("R1 ready", int'(ready), 0);
        check("R1 fault", int'(pwr_fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_boot();
        core_ok = 1'b1;
        io_ok   = 1'b1;
        measure_boot("boot", 0);
        check("R10 bus64", int'(strap_bus64), 1);
        check("R10 endian", int'(strap_big_endian), 1);
        check("R10 div", int'(strap_div), 5);
        check("R10 ratio", int'(div_ratio_x2), 9);
        check("R10 ooo", int'(strap_ooo_ret), 0);
    endtask

    task automatic t_warm();
        int n;
        warm_req = 1'b1;
        @(negedge clk);
        warm_req = 1'b0;
        check("R6 warm low", int'(warm_rst_n), 0);
        check("R6 cold high", int'(cold_rst_n), 1);
        check("R6 ready low", int'(ready), 0);
        n = 1;
        while (!warm_rst_n && n < 1000) begin
            @(negedge clk);
            n++;
            if (!warm_rst_n) check("R6 cold stays", int'(cold_rst_n), 1);
        end
        check("R6 pulse", n, WARM + 1);
        check("R6 ready lags", int'(ready), 0);
        @(negedge clk);
        check("R6 ready back", int'(ready), 1);
        check("R10 div kept", int'(strap_div), 5);
    endtask

    task automatic t_loss();
        io_ok = 1'b0;
        #1;
        check("R8 cold", int'(cold_rst_n), 0);
        check("R8 warm", int'(warm_rst_n), 0);
        check("R8 ready", int'(ready), 0);
        @(negedge clk);
        io_ok = 1'b1;
        measure_boot("R8 restart", 0);
    endtask

    task automatic t_warm_ignored();
        drop_all();
        core_ok = 1'b1;
        io_ok   = 1'b1;
        measure_boot("R7 ignored", 10);
    endtask

    task automatic t_skew_ok();
        drop_all();
        core_ok = 1'b1;
        wait_neg(LIMIT - 1);
        check("R2 no fault", int'(pwr_fault), 0);
        io_ok = 1'b1;
        measure_boot("R2 in window", 0);
        check("R2 still no fault", int'(pwr_fault), 0);
    endtask

    task automatic t_skew_fault();
        drop_all();
        io_ok = 1'b1;
        wait_neg(LIMIT - 1);
        check("R2 edge", int'(pwr_fault), 0);
        @(negedge clk);
        check("R2 fault", int'(pwr_fault), 1);
        core_ok = 1'b1;
        wait_neg(HOLD + 20);
        check("R9 cold held", int'(cold_rst_n), 0);
        check("R9 fault kept", int'(pwr_fault), 1);
        core_ok = 1'b0;
        io_ok   = 1'b0;
        @(negedge clk);
        check("R9 fault clear", int'(pwr_fault), 0);
    endtask

    initial begin
        t_reset();
        t_boot();
        t_warm();
        t_loss();
        t_warm_ignored();
        t_skew_fault();
        t_skew_ok();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule